// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Unit

This block holds a 64-bit signed accumulator and feeds it from a 16x16 signed multiplier. Each clock the host presents a command code and two 32-bit operands. The commands load or add a product of either the upper or the lower operand halves. Other commands write one 32-bit word of the accumulator, read one of three 32-bit windows of it, or apply a shift-round-saturate step.

Every valid command finishes in a single clock. A one-cycle `done` pulse follows it in the next cycle. A read also registers the selected window onto `rdata`, where it holds until the next read. Command codes outside the defined set do nothing.

Top module: `mac_accum`

## Requirements
- R1: A synchronous reset clears the accumulator to zero and drives `rdata` and `done` low.
- R2: Command 1 (product of upper halves) takes operand bits 31:16 of `opa` and `opb` as signed 16-bit values. It writes their sign-extended product into the accumulator. Command 3 adds that same product to the accumulator.
- R3: Command 2 (product of lower halves) and command 4 (add product of lower halves) behave like commands 1 and 3, but use operand bits 15:0.
- R4: The additions made by commands 3 and 4 wrap modulo 2^64, and no flag is raised.
- R5: Command 5 loads accumulator bits 63:32 from `opa`, and command 6 loads bits 31:0 from `opa`. The other half is unchanged in both cases.
- R6: Reads return a 32-bit window of the accumulator on `rdata` one cycle later. Command 7 returns bits 63:32, command 8 returns bits 47:16 and command 9 returns bits 31:0. Reads leave the accumulator unchanged, and `rdata` holds its value when no read is issued.
- R7: Command 10 (round) shifts the accumulator left by `opa` places and adds 0x80000000. It then clamps the signed result to at most 0x00007FFF00000000 and at least 0xFFFF800000000000. When no clamp applies, it clears bits 31:0.
- R8: The round shift is 2 when `opa` equals 2. Any other `opa` value gives a shift of 1.
- R9: Each command code from 1 to 10 raises `done` for exactly the next cycle. Code 0 and codes 11 to 15 leave the accumulator unchanged and keep `done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 4 | Command code |
| opa | input | 32 | First operand / write data / shift amount |
| opb | input | 32 | Second multiplier operand |
| rdata | output | 32 | Registered read window |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench drives both saturation limits. A design that compared the values unsigned, or that clamped before adding the rounding constant, would produce the wrong limit or a nonzero low word. It also drives a shift amount of 3, which must act as 1, and an addition that carries across bit 63. A design with sign-extension mistakes would show those mistakes in the high word of negative products. The bench also reads the middle window after separate high and low writes. This shows whether either write disturbed the other half.

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     cmd,
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  output logic [OPW-1:0] rdata,
  output logic           done
);
  localparam int AW = 2 * OPW;
  localparam int HW = OPW / 2;
  localparam logic [AW-1:0] RND_ADD = {{(OPW){1'b0}}, 1'b1, {(OPW-1){1'b0}}};
  localparam logic [AW-1:0] SAT_HI  = {{(HW+1){1'b0}}, {(HW-1){1'b1}}, {(OPW){1'b0}}};
  localparam logic [AW-1:0] SAT_LO  = {{(HW+1){1'b1}}, {(AW-HW-1){1'b0}}};

  typedef enum logic [3:0] {
    C_NOP = 4'd0, C_MULH = 4'd1, C_MULL = 4'd2, C_MACH = 4'd3, C_MACL = 4'd4,
    C_WRHI = 4'd5, C_WRLO = 4'd6, C_RDHI = 4'd7, C_RDMID = 4'd8, C_RDLO = 4'd9,
    C_RND = 4'd10
  } cmd_e;

  logic [AW-1:0] acc, acc_nx, prod_ext, shifted, rounded, sat_val;
  logic signed [HW-1:0] fa, fb;
  logic signed [OPW-1:0] prod;
  logic use_hi, valid;

  assign use_hi   = (cmd == C_MULH) || (cmd == C_MACH);
  assign fa       = use_hi ? opa[OPW-1:HW] : opa[HW-1:0];
  assign fb       = use_hi ? opb[OPW-1:HW] : opb[HW-1:0];
  assign prod     = fa * fb;
  assign prod_ext = {{(AW-OPW){prod[OPW-1]}}, prod};
  assign valid    = (cmd >= C_MULH) && (cmd <= C_RND);

  assign shifted = (opa == OPW'(2)) ? (acc << 2) : (acc << 1);
  assign rounded = shifted + RND_ADD;

  always_comb begin
    if ($signed(rounded) > $signed(SAT_HI))      sat_val = SAT_HI;
    else if ($signed(rounded) < $signed(SAT_LO)) sat_val = SAT_LO;
    else                                         sat_val = {rounded[AW-1:OPW], {(OPW){1'b0}}};
  end

  always_comb begin
    acc_nx = acc;
    case (cmd)
      C_MULH, C_MULL: acc_nx = prod_ext;
      C_MACH, C_MACL: acc_nx = acc + prod_ext;
      C_WRHI:         acc_nx = {opa, acc[OPW-1:0]};
      C_WRLO:         acc_nx = {acc[AW-1:OPW], opa};
      C_RND:          acc_nx = sat_val;
      default:        acc_nx = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      acc  <= acc_nx;
      done <= valid;
      case (cmd)
        C_RDHI:  rdata <= acc[AW-1:OPW];
        C_RDMID: rdata <= acc[AW-HW-1:HW];
        C_RDLO:  rdata <= acc[OPW-1:0];
        default: rdata <= rdata;
      endcase
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (acc == '0 && !done));

  // R5
  write_hi_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == C_WRHI && !$past(rst)) |-> (acc[AW-1:OPW] == $past(opa) && acc[OPW-1:0] == $past(acc[OPW-1:0])));

  // R7
  round_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd) == C_RND && !$past(rst)) |-> (acc[OPW-1:0] == '0 &&
      $signed(acc) <= $signed(SAT_HI) && $signed(acc) >= $signed(SAT_LO)));

  // R6
  read_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd == C_RDHI || cmd == C_RDMID || cmd == C_RDLO)) |=> $stable(acc));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid) |=> ($stable(acc) && !done));
endmodule

// File: tb/mac_accum_tb.sv
module mac_accum_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cmd = 4'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] rdata;
  logic done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mac_accum u_dut (.clk(clk), .rst(rst), .cmd(cmd), .opa(opa), .opb(opb), .rdata(rdata), .done(done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic exp_done, input string req);
    @(negedge clk);
    cmd = c; opa = a; opb = b;
    @(negedge clk);
    cmd = 4'd0;
    chk(req, {31'd0, done}, {31'd0, exp_done});
  endtask

  task automatic read_acc(input string req, input logic [63:0] exp);
    issue(4'd7, 0, 0, 1'b1, req); chk(req, rdata, exp[63:32]);
    issue(4'd9, 0, 0, 1'b1, req); chk(req, rdata, exp[31:0]);
  endtask

  task automatic load(input logic [63:0] v);
    issue(4'd5, v[63:32], 0, 1'b1, "R5");
    issue(4'd6, v[31:0], 0, 1'b1, "R5");
  endtask

  task automatic t_reset;
    @(negedge clk); chk("R1", rdata, 32'h0); chk("R1", {31'd0, done}, 32'h0);
    read_acc("R1", 64'h0);
  endtask

  task automatic t_mul;
    issue(4'd1, 32'hFFFE_1234, 32'h0003_8000, 1'b1, "R2 mulh");
    read_acc("R2 mulh", 64'hFFFFFFFF_FFFFFFFA);
    issue(4'd3, 32'h0004_0000, 32'h0005_0000, 1'b1, "R2 mach");
    read_acc("R2 mach", 64'h0000000000000000E);
    issue(4'd2, 32'hAAAA_7FFF, 32'h5555_7FFF, 1'b1, "R3 mull");
    read_acc("R3 mull", 64'h00000000_3FFF0001);
    issue(4'd4, 32'h0000_8000, 32'h0000_0002, 1'b1, "R3 macl");
    read_acc("R3 macl", 64'h00000000_3FFE0001);
  endtask

  task automatic t_wrap;
    load(64'h7FFFFFFF_FFFFFFFF);
    issue(4'd3, 32'h0001_0000, 32'h0001_0000, 1'b1, "R4");
    read_acc("R4 carry", 64'h80000000_00000000);
    load(64'hFFFFFFFF_FFFFFFFF);
    issue(4'd4, 32'h0000_0001, 32'h0000_0001, 1'b1, "R4");
    read_acc("R4 wrap", 64'h0);
  endtask

  task automatic t_rw;
    load(64'h12345678_9ABCDEF0);
    issue(4'd8, 0, 0, 1'b1, "R6 mid"); chk("R6 mid", rdata, 32'h5678_9ABC);
    issue(4'd0, 0, 0, 1'b0, "R6 hold"); chk("R6 hold", rdata, 32'h5678_9ABC);
    issue(4'd5, 32'hCAFEF00D, 0, 1'b1, "R5");
    read_acc("R5 hi only", 64'hCAFEF00D_9ABCDEF0);
  endtask

  task automatic t_round;
    load(64'h00008000_00000000);
    issue(4'd10, 1, 0, 1'b1, "R7");
    read_acc("R7 pos clamp", 64'h00007FFF_00000000);
    load(64'hFFFF0000_00000000);
    issue(4'd10, 1, 0, 1'b1, "R7");
    read_acc("R7 neg clamp", 64'hFFFF8000_00000000);
    load(64'h00000001_80000000);
    issue(4'd10, 1, 0, 1'b1, "R7");
    read_acc("R7 round", 64'h00000003_00000000);
    load(64'h00000012_7FFFFFFF);
    issue(4'd10, 2, 0, 1'b1, "R8");
    read_acc("R8 shift2", 64'h0000004A_00000000);
    load(64'h00000005_00000000);
    issue(4'd10, 3, 0, 1'b1, "R8");
    read_acc("R8 shift3 as 1", 64'h0000000A_00000000);
  endtask

  task automatic t_idle;
    load(64'h01020304_05060708);
    issue(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 nop");
    issue(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 code11");
    issue(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 code15");
    read_acc("R9 unchanged", 64'h01020304_05060708);
    @(negedge clk); chk("R9 one cycle", {31'd0, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_mul;
    t_wrap;
    t_rw;
    t_round;
    t_idle;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule